// File: doc/BRIEF.md
# Parallel Port Debouncer with Edge Flags

This block cleans up a multi-bit port of slow, bouncy inputs such as switches or contacts. Every bit is filtered on its own, and all bits are filtered in the same cycle. On each cycle where the sample strobe is high, the block takes in one raw sample per bit. It then judges each bit over a three-sample window: the sample just taken and the two strobed samples before it. A bit's filtered level goes to 1 only after three ones in a row. It goes to 0 only after three zeros in a row. Any mixed window leaves the level as it was.

Next to the filtered level, the block gives two one-shot vectors. One marks the bits whose filtered level has just gone from 0 to 1. The other marks the bits whose filtered level has just gone from 1 to 0. A flag is high in the clock cycle that follows the strobed edge on which the level changed, and for no other cycle. The strobe lets a slow tick set the sampling period while the block runs on the fast system clock. Input synchronisation is left to the logic in front of the block.

Top module: `parallel_debounce`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, the filtered level, the rise flags and the fall flags are all 0.
- R2: On a clock edge where the strobe is high, a bit whose raw input is 1 and whose two previous strobed samples were both 1 has filtered level 1 after that edge.
- R3: On a clock edge where the strobe is high, a bit whose raw input is 0 and whose two previous strobed samples were both 0 has filtered level 0 after that edge.
- R4: On a strobed edge where a bit's three-sample window holds both values, that bit's filtered level does not change.
- R5: Each bit is filtered only from its own samples, whatever the other bits are doing.
- R6: A rise flag bit is 1 for exactly the one cycle after a strobed edge that moved that bit's level from 0 to 1. At all other times it is 0.
- R7: A fall flag bit is 1 for exactly the one cycle after a strobed edge that moved that bit's level from 1 to 0. At all other times it is 0.
- R8: The rise flag and the fall flag of the same bit are never 1 at the same time.
- R9: On an edge where the strobe is low, the filtered level and the sample history do not change, and all flags are 0 after that edge.
- R10: After reset the history counts as all zeros. The first strobed samples raise no flag unless a filtered bit really changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, active on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample strobe; history and levels advance only while it is high |
| raw_in | input | WIDTH | Raw input port, already synchronised |
| level_out | output | WIDTH | Filtered level, one bit per input |
| rise_out | output | WIDTH | One-cycle flag per bit for a filtered 0-to-1 change |
| fall_out | output | WIDTH | One-cycle flag per bit for a filtered 1-to-0 change |

## Verification
Three kinds of pattern are used.

The first is a fourteen-sample bounce trace, applied to every bit at once. It separates a design that switches on three equal samples in a row from one that switches early or late. It also catches a design that lets a single glitch through.

The second is a long sweep in which each bit runs a square wave of its own period, with one-sample glitches on top. It shows whether bits are kept independent and whether the history is indexed per bit.

The third breaks the strobe up with gaps during that sweep, including a gap of several cycles. This tells apart a design whose history and flags follow the strobe from one that shifts on every clock or keeps its flags up through the gap. A freshly reset run driven with zeros checks that no flag is raised at start-up.

// File: rtl/db_pkg.sv
package db_pkg;

    // number of earlier strobed samples kept per bit (window = current + these)
    localparam int HIST_LEN = 2;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } act_e;

    // decide what the filtered level of one bit does for a given window
    function automatic act_e classify(input logic cur, input logic [HIST_LEN-1:0] past);
        act_e a;
        if (cur && (&past))
            a = ACT_SET;
        else if (!cur && !(|past))
            a = ACT_CLR;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/db_history.sv
module db_history
    import db_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sample_en,
    input  logic [WIDTH-1:0]              raw_in,
    output logic [WIDTH-1:0][HIST_LEN-1:0] past_o
);

    // per bit: shift register of the previous strobed samples, [0] newest
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [HIST_LEN-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst)
                sh_q <= '0;
            else if (sample_en)
                sh_q <= {sh_q[HIST_LEN-2:0], raw_in[b]};
        end
        assign past_o[b] = sh_q;
    end

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(past_o));

    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> (past_o[0][0] == $past(raw_in[0])));

endmodule

// File: rtl/db_level.sv
module db_level
    import db_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sample_en,
    input  logic [WIDTH-1:0]              raw_in,
    input  logic [WIDTH-1:0][HIST_LEN-1:0] past_i,
    output logic [WIDTH-1:0]              level_o,
    output logic [WIDTH-1:0]              rise_o,
    output logic [WIDTH-1:0]              fall_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        act_e act;
        logic lvl_q, rise_q, fall_q, lvl_d;

        always_comb begin
            act = classify(raw_in[b], past_i[b]);
            unique case (act)
                ACT_SET: lvl_d = 1'b1;
                ACT_CLR: lvl_d = 1'b0;
                default: lvl_d = lvl_q;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q  <= 1'b0;
                rise_q <= 1'b0;
                fall_q <= 1'b0;
            end else if (sample_en) begin
                lvl_q  <= lvl_d;
                rise_q <= lvl_d & ~lvl_q;
                fall_q <= ~lvl_d & lvl_q;
            end else begin
                rise_q <= 1'b0;
                fall_q <= 1'b0;
            end
        end

        assign level_o[b] = lvl_q;
        assign rise_o[b]  = rise_q;
        assign fall_o[b]  = fall_q;
    end

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_o & fall_o) == '0);

    // R6
    rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ((level_o & rise_o) == rise_o) && (($past(level_o) & rise_o) == '0));

    // R7
    fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ((level_o & fall_o) == '0) && (($past(level_o) & fall_o) == fall_o));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(level_o) && rise_o == '0 && fall_o == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (level_o == '0 && rise_o == '0 && fall_o == '0));

endmodule

// File: rtl/parallel_debounce.sv
module parallel_debounce
    import db_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] level_out,
    output logic [WIDTH-1:0] rise_out,
    output logic [WIDTH-1:0] fall_out
);

    logic [WIDTH-1:0][HIST_LEN-1:0] past_w;

    db_history #(.WIDTH(WIDTH)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .raw_in    (raw_in),
        .past_o    (past_w)
    );

    db_level #(.WIDTH(WIDTH)) u_lvl (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .raw_in    (raw_in),
        .past_i    (past_w),
        .level_o   (level_out),
        .rise_o    (rise_out),
        .fall_o    (fall_out)
    );

    // R2: a window of all ones forces the level high
    set_win_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en && (raw_in[0] && (&past_w[0])) |=> level_out[0]);

    // R3: a window of all zeros forces the level low
    clr_win_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en && (!raw_in[0] && !(|past_w[0])) |=> !level_out[0]);

endmodule

// File: tb/sim_parallel_debounce.sv
module sim_parallel_debounce;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         sample_en;
    logic [W-1:0] raw_in;
    logic [W-1:0] level_out, rise_out, fall_out;

    int n_tests = 0;
    int n_fail  = 0;

    // bench-side reference state
    logic [W-1:0] m_h0, m_h1, m_lvl, m_rise, m_fall;

    always #2.5 clk = ~clk;

    parallel_debounce #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .sample_en(sample_en), .raw_in(raw_in),
        .level_out(level_out), .rise_out(rise_out), .fall_out(fall_out)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_h0 = '0; m_h1 = '0; m_lvl = '0; m_rise = '0; m_fall = '0;
    endtask

    // drive at negedge, clock once, compare at following negedge
    task automatic step(input logic en, input logic [W-1:0] r);
        logic [W-1:0] ones, zeros, nxt;
        sample_en = en;
        raw_in    = r;
        @(posedge clk);
        if (en) begin
            ones   = r & m_h0 & m_h1;
            zeros  = ~r & ~m_h0 & ~m_h1;
            nxt    = (m_lvl | ones) & ~zeros;
            m_rise = nxt & ~m_lvl;
            m_fall = ~nxt & m_lvl;
            m_lvl  = nxt;
            m_h1   = m_h0;
            m_h0   = r;
        end else begin
            m_rise = '0;
            m_fall = '0;
        end
        @(negedge clk);
        check("R2 R3 R4 R5 level", level_out, m_lvl);
        check(en ? "R6 rise" : "R9 rise idle", rise_out, m_rise);
        check(en ? "R7 fall" : "R9 fall idle", fall_out, m_fall);
        check("R8 exclusive", rise_out & fall_out, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1; sample_en = 1'b0; raw_in = '0;
        @(negedge clk); @(negedge clk);
        check("R1 level in reset", level_out, '0);
        check("R1 flags in reset", rise_out | fall_out, '0);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        fork
            begin
                logic [13:0] trace;
                logic [W-1:0] r;
                do_reset();
                // R10: zeros after reset raise nothing
                for (int k = 0; k < 3; k++) step(1'b1, '0);
                check("R10 no flag after zeros", level_out | rise_out | fall_out, '0);
                // bounce trace on every bit (first sample first)
                trace = 14'b10010100010111;
                for (int k = 13; k >= 0; k--) step(1'b1, {W{trace[k]}});
                check("R2 trace ends high", level_out, '1);
                // R4: fixed glitch cases from a high level
                step(1'b1, '0); step(1'b1, '1); step(1'b1, '0); step(1'b1, '0);
                check("R4 glitch held", level_out, '1);
                step(1'b1, '0);
                check("R3 three zeros clear", level_out, '0);
                check("R7 fall flag", fall_out, '1);
                // per-bit square waves with glitches and strobe gaps
                for (int s = 0; s < 2000; s++) begin
                    for (int b = 0; b < W; b++)
                        r[b] = ((s / (b + 2)) % 2) == 1;
                    if ((s % 37) == 5) r = r ^ 8'h5A;
                    step((s % 7) != 3 && (s % 101) > 4, r);
                end
                // R9: long gap with changing raw input
                for (int k = 0; k < 6; k++) step(1'b0, 8'hFF ^ k[7:0]);
                // R1: reset mid-activity
                do_reset();
                step(1'b1, '1);
                check("R10 single one no flag", rise_out | level_out, '0);
            end
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule